// File: doc/BRIEF.md
# Attributed Variable-Length Pixel Serializer

This block takes one character-row object from a host processor and sends it to a display as a synchronous serial pixel stream. The host loads the object with three byte writes on an 8-bit write port. A 2-bit select picks the target register for each byte. The third write sets the attributes and starts the transfer: dot count (1 to 16), mirrored bit order, pixel inversion, and a zoom factor that repeats each pixel 1 to 4 times.

The serial clock runs at one quarter of the block clock. The block drives three outputs:
- a serial data line to the display;
- the serial clock to the display;
- a busy flag back to the host.

While the busy flag is high, the block ignores every write. After a transfer the host may reload only the control register to send the same pixel data again with new attributes.

Top module: `attr_pixel_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, and for the whole cycle after it, `busy`, `ser_clk` and `ser_data` are 0. This holds when reset interrupts a transfer.
- R2: A write with `wr_en` high and `busy` low stores `wr_data` by `wr_sel`:
  - select 0 stores pixel bits 7:0;
  - select 1 stores pixel bits 15:8;
  - select 2 loads the control byte: length-1 in bits 3:0, zoom-1 in bits 5:4, invert in bit 6, mirror in bit 7;
  - select 3 changes nothing.
  Pixel bytes keep their values from one object to the next.
- R3: A select-2 write accepted at a clock edge makes `busy` high from that edge on.
- R4: While `busy` is high, `ser_clk` is low for two clock cycles and then high for two, starting low in the first busy cycle. It is low whenever `busy` is low.
- R5: One object holds `busy` high for exactly 4·length·zoom cycles and gives exactly length·zoom rising edges of `ser_clk`.
- R6: With mirror clear, pixels go out from bit length-1 down to bit 0.
- R7: With mirror set, pixels go out from bit 0 up to bit length-1.
- R8: With zoom N, each pixel is presented for N consecutive serial clock periods.
- R9: With invert set, each pixel is complemented on `ser_data`.
- R10: `ser_data` changes only on the edge that starts a low phase of `ser_clk`. It holds its value through the following high phase.
- R11: Writes of any select while `busy` is high change no register and do not restart or lengthen the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write byte |
| ser_data | output | 1 | Serial pixel data to the display |
| ser_clk | output | 1 | Serial clock to the display, idles low |
| busy | output | 1 | High while an object is being sent |

## Verification
Directed objects cover the following cases:
- single-dot and full 16-dot lengths, which separate an off-by-one in the length counter from a correct end of transfer;
- a 9-dot mirrored object at zoom 1, which shows whether the bit order reverses across the byte boundary;
- zoom 4 with inversion, which tells a repeat counter that holds the pixel from one that advances it early.

Writes injected in the middle of a transfer, a select-3 write, and a restart that writes only the control byte show whether the pixel registers are protected and kept. Random objects with a fixed seed then mix all attribute combinations against a bench model of the expected pixel stream.

// File: rtl/vlser_pkg.sv
package vlser_pkg;
    parameter int BYTE_W = 8;
    parameter int DATA_W = 2 * BYTE_W;
    parameter int LEN_W  = $clog2(DATA_W);
    parameter int ZOOM_W = 2;
    parameter int PH_W   = 2;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // Layout matches the control byte: mirror 7, invert 6, zoom-1 5:4, length-1 3:0
    typedef struct packed {
        logic              mirror;
        logic              invert;
        logic [ZOOM_W-1:0] zoom_m1;
        logic [LEN_W-1:0]  len_m1;
    } attr_t;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
        attr_t             attr;
    } obj_t;

    // Places the pixels in send order, first pixel at the MSB
    function automatic logic [DATA_W-1:0] align_stream(logic [DATA_W-1:0] bits, attr_t a);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int k = 0; k < DATA_W; k++) begin
            if (k <= int'(a.len_m1)) begin
                r[DATA_W-1-k] = a.mirror ? bits[k] : bits[int'(a.len_m1) - k];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/vlser_host_regs.sv
module vlser_host_regs
    import vlser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              busy,
    output obj_t              load_obj,
    output logic              start
);
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic              accept;

    assign accept = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept) begin
            case (wr_sel)
                SEL_LO:  lo_q <= wr_data;
                SEL_HI:  hi_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign start         = accept && (wr_sel == SEL_CTL);
    assign load_obj.bits = {hi_q, lo_q};
    assign load_obj.attr = attr_t'(wr_data);

    // R11
    regs_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> (lo_q == $past(lo_q) && hi_q == $past(hi_q)));
endmodule

// File: rtl/vlser_phase_gen.sv
module vlser_phase_gen
    import vlser_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    output logic [PH_W-1:0] phase,
    output logic            period_end
);
    localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else begin
            phase <= phase + {{(PH_W-1){1'b0}}, 1'b1};
        end
    end

    assign period_end = run && (phase == PH_LAST);

    // R4
    phase_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (phase == '0));
endmodule

// File: rtl/vlser_shift_core.sv
module vlser_shift_core
    import vlser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  obj_t load_obj,
    input  logic period_end,
    output logic busy,
    output logic pix_out
);
    logic [DATA_W-1:0] shreg;
    logic [LEN_W-1:0]  bit_cnt;
    logic [ZOOM_W-1:0] rep_cnt;
    attr_t             attr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
            rep_cnt <= '0;
            attr_q  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            shreg   <= align_stream(load_obj.bits, load_obj.attr);
            bit_cnt <= '0;
            rep_cnt <= '0;
            attr_q  <= load_obj.attr;
        end else if (period_end) begin
            if (rep_cnt == attr_q.zoom_m1) begin
                rep_cnt <= '0;
                if (bit_cnt == attr_q.len_m1) begin
                    busy <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + {{(LEN_W-1){1'b0}}, 1'b1};
                    shreg   <= {shreg[DATA_W-2:0], 1'b0};
                end
            end else begin
                rep_cnt <= rep_cnt + {{(ZOOM_W-1){1'b0}}, 1'b1};
            end
        end
    end

    assign pix_out = shreg[DATA_W-1] ^ attr_q.invert;

    // R5
    busy_ends_on_period_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(period_end));

    // R8
    rep_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rep_cnt <= attr_q.zoom_m1 && bit_cnt <= attr_q.len_m1));
endmodule

// File: rtl/attr_pixel_serializer.sv
module attr_pixel_serializer
    import vlser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              busy
);
    obj_t            load_obj;
    logic            start;
    logic [PH_W-1:0] phase;
    logic            period_end;
    logic            pix_out;

    vlser_host_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .busy     (busy),
        .load_obj (load_obj),
        .start    (start)
    );

    vlser_phase_gen u_phase (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .phase      (phase),
        .period_end (period_end)
    );

    vlser_shift_core u_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .load_obj   (load_obj),
        .period_end (period_end),
        .busy       (busy),
        .pix_out    (pix_out)
    );

    assign ser_clk  = busy & phase[PH_W-1];
    assign ser_data = busy & pix_out;

    // R10
    data_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> (ser_data == $past(ser_data)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && !ser_data));
endmodule

// File: tb/attr_pixel_serializer_tb.sv
module attr_pixel_serializer_tb_top;
    localparam int CLK_PERIOD = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ser_data, ser_clk, busy;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [7:0] m_lo = 8'd0;
    logic [7:0] m_hi = 8'd0;

    attr_pixel_serializer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ser_data(ser_data), .ser_clk(ser_clk), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit exp_bit(input logic [7:0] lo, input logic [7:0] hi,
                                   input logic [7:0] ctl, input int i);
        int len, zoom, k, src;
        logic [15:0] d;
        d    = {hi, lo};
        len  = int'(ctl[3:0]) + 1;
        zoom = int'(ctl[5:4]) + 1;
        k    = i / zoom;
        src  = ctl[7] ? k : (len - 1 - k);
        return d[src] ^ ctl[6];
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 2'd0) m_lo = d;
        if (sel == 2'd1) m_hi = d;
    endtask

    // Starts an object by writing the control byte, then checks the whole transfer
    task automatic run_obj(input logic [7:0] ctl, input bit inject, output int bad);
        int len, zoom, c, edges;
        bit prev_clk, prev_d;
        string sreq;
        len  = int'(ctl[3:0]) + 1;
        zoom = int'(ctl[5:4]) + 1;
        sreq = ctl[6] ? "R9" : (zoom > 1 ? "R8" : (ctl[7] ? "R7" : "R6"));
        bad = 0;
        wr(2'd2, ctl);
        chk(busy == 1'b1, "R3", int'(busy), 1);
        c = 0; edges = 0; prev_clk = 1'b0; prev_d = 1'b0;
        while (busy && c < 2000) begin
            if (ser_clk !== (c % 4 >= 2)) begin
                bad++;
                chk(1'b0, "R4", int'(ser_clk), int'(c % 4 >= 2));
            end
            if (c > 0 && ser_data !== prev_d && (c % 4) != 0) begin
                bad++;
                chk(1'b0, "R10", c % 4, 0);
            end
            if (ser_clk && !prev_clk) begin
                if (ser_data !== exp_bit(m_lo, m_hi, ctl, edges)) begin
                    bad++;
                    chk(1'b0, sreq, int'(ser_data), int'(exp_bit(m_lo, m_hi, ctl, edges)));
                end
                edges++;
            end
            prev_clk = ser_clk; prev_d = ser_data;
            if (inject && (c == 5 || c == 9)) begin
                wr_en = 1'b1; wr_sel = 2'($urandom_range(0, 3)); wr_data = 8'($urandom);
            end
            @(negedge clk);
            wr_en = 1'b0;
            c++;
        end
        chk(c == 4 * len * zoom, "R5", c, 4 * len * zoom);
        chk(edges == len * zoom, "R5", edges, len * zoom);
        chk(!ser_clk && !ser_data, "R4", int'({ser_clk, ser_data}), 0);
        chk(bad == 0, sreq, bad, 0);
        if (c != 4 * len * zoom || edges != len * zoom) bad++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int bad;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!busy && !ser_clk && !ser_data, "R1", int'({busy, ser_clk, ser_data}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !ser_clk && !ser_data, "R1", int'({busy, ser_clk, ser_data}), 0);

        // R6: plain order, 16 dots
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        run_obj(8'h0F, 1'b0, bad);
        // R6: single dot
        wr(2'd0, 8'h01);
        run_obj(8'h00, 1'b0, bad);
        // R7: worst case 9 dots mirrored zoom 1
        wr(2'd0, 8'h6B); wr(2'd1, 8'h01);
        run_obj(8'h88, 1'b0, bad);
        chk(bad == 0, "R7", bad, 0);
        // R8 and R9: zoom 4 with inversion, 16 dots, mirrored
        wr(2'd0, 8'hC3); wr(2'd1, 8'h5A);
        run_obj(8'hFF, 1'b0, bad);
        run_obj(8'h35, 1'b0, bad);
        chk(bad == 0, "R8", bad, 0);
        run_obj(8'h47, 1'b0, bad);
        chk(bad == 0, "R9", bad, 0);

        // R2: select 3 writes nothing; control-only restart reuses pixel bytes
        wr(2'd3, 8'hFF);
        run_obj(8'h0B, 1'b0, bad);
        chk(bad == 0, "R2", bad, 0);

        // R11: writes during busy are ignored
        wr(2'd0, 8'h96); wr(2'd1, 8'h0F);
        run_obj(8'h1E, 1'b1, bad);
        chk(bad == 0, "R11", bad, 0);
        run_obj(8'h0F, 1'b0, bad);
        chk(bad == 0, "R11", bad, 0);

        // R1: reset in the middle of a transfer
        wr(2'd2, 8'h3F);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !ser_clk && !ser_data, "R1", int'({busy, ser_clk, ser_data}), 0);
        rst = 1'b0;
        m_lo = 8'd0; m_hi = 8'd0;
        @(negedge clk);
        chk(!busy && !ser_clk && !ser_data, "R1", int'({busy, ser_clk, ser_data}), 0);
        run_obj(8'h07, 1'b0, bad);
        chk(bad == 0, "R2", bad, 0);

        // Random objects
        for (int n = 0; n < 40; n++) begin
            wr(2'd0, 8'($urandom));
            wr(2'd1, 8'($urandom));
            run_obj(8'($urandom), (n % 5) == 0, bad);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule